// File: doc/BRIEF.md
# Auxiliary-Register Address Generator

This block produces the operand address for register-indirect data accesses in a DSP datapath. It also produces the post-modified value of the selected auxiliary register. It holds a bank of auxiliary pointer registers. Each cycle it reads the register named by the select input and forms the effective address under a mode code. It also forms the register's updated value.

The supported updates are:
- plain and constant-offset access, where the register keeps its value;
- linear step up or down by one;
- addition of an index value;
- circular stepping inside a buffer whose length comes from a block-size input;
- reverse-carry addition of the index, which walks FFT data in bit-reversed order.

Address and update logic is combinational. The bank is written on the clock edge when write-back is enabled. A separate load port initialises any register. Instruction decode and the memory access itself sit outside the block.

Top module: `ar_addr_gen`

## Requirements
- R1: After reset every auxiliary register reads as 0x0000.
- R2: Mode 0 (plain): `addr` equals the selected register and `ar_next` equals the register unchanged.
- R3: Mode 1 (offset): `addr` equals register plus `offset` modulo 2^16, and `ar_next` equals the register unchanged.
- R4: Mode 2 gives `ar_next` = register + 1 and mode 3 gives `ar_next` = register - 1, both modulo 2^16. In both modes `addr` equals the register.
- R5: Mode 4 gives `ar_next` = register + `idx` modulo 2^16, with `addr` equal to the register.
- R6: Circular modes 5 (step up), 6 (step down) and 7 (add `idx`) apply when `bk` is nonzero. They use the following definitions:
  - P is the smallest power of two at or above `bk`.
  - The base is the register with its low log2(P) bits cleared.
  - The position is those low bits.
  - Step up gives position+1, or 0 when that reaches `bk`.
  - Step down gives `bk`-1 when the position is 0, otherwise position-1.
  - Add gives position+`idx`, less `bk` when the sum is at or above `bk`.
  - `ar_next` = base + (new position modulo P).
  - `addr` equals the register.
- R7: With `bk` = 0, modes 5, 6 and 7 behave exactly as modes 2, 3 and 4.
- R8: Mode 8 (reverse carry): `ar_next` is the 16-bit bit-reversal of (reversed register + reversed `idx`), with the final carry dropped. `addr` equals the register.
- R9: When `wr_en` is high, `ar_next` is stored into the selected register at the clock edge. When `wr_en` is low, no register changes through the write-back path.
- R10: When `ld_en` is high, `ld_val` is stored into register `ld_sel` at the edge. If both ports target the same register in one cycle, the load wins. In that cycle `addr` still uses the old value.
- R11: Mode codes 9 to 15 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Selected auxiliary register |
| mode | input | 4 | Addressing mode code |
| offset | input | 16 | Constant offset for mode 1 |
| idx | input | 16 | Index value for add modes |
| bk | input | 16 | Circular block size, 0 disables wrap |
| wr_en | input | 1 | Store `ar_next` into the selected register |
| ld_en | input | 1 | Load port enable |
| ld_sel | input | 3 | Register targeted by the load port |
| ld_val | input | 16 | Value written by the load port |
| addr | output | 16 | Effective data address |
| ar_next | output | 16 | Post-modified register value |

## Verification
The load port and the write-back path can both strike in one cycle, either on the same register or on two different ones. The bench provokes the same-register case directly: it loads the register being post-modified while `wr_en` is high. In the next cycle it reads that register in plain mode and expects the loaded value, not the modified one. A second directed step loads a different register and expects both writes to land. The random phase draws both enables and both selects freely, so collisions recur throughout. The reference model applies write-back first and load second on every one of them.

// File: rtl/ar_addr_gen.sv
module ar_addr_gen #(
  parameter int AW  = 16,
  parameter int NAR = 8,
  localparam int SW = $clog2(NAR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] bk,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ar_next
);

  localparam logic [3:0] M_PLAIN = 4'd0, M_OFS = 4'd1, M_INC = 4'd2, M_DEC = 4'd3,
                         M_ADD = 4'd4, M_CINC = 4'd5, M_CDEC = 4'd6, M_CADD = 4'd7,
                         M_REV = 4'd8;

  logic [AW-1:0] bank [NAR];
  logic [AW-1:0] cur, mask, base, pos, circ_pos, rev_sum;
  logic [AW:0]   pos_up, pos_sum, pos_wrap;
  logic          circ_on;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  assign cur     = bank[sel];
  assign circ_on = (bk != '0);

  always_comb begin
    mask = bk - 1'b1;
    for (int s = 1; s < AW; s = s << 1) mask = mask | (mask >> s);
  end

  assign base     = cur & ~mask;
  assign pos      = cur & mask;
  assign pos_up   = {1'b0, pos} + 1'b1;
  assign pos_sum  = {1'b0, pos} + {1'b0, idx};
  assign pos_wrap = (pos_sum >= {1'b0, bk}) ? pos_sum - {1'b0, bk} : pos_sum;
  assign rev_sum  = flip(flip(cur) + flip(idx));

  always_comb begin
    circ_pos = pos;
    unique case (mode)
      M_CINC:  circ_pos = (pos_up >= {1'b0, bk}) ? '0 : pos_up[AW-1:0];
      M_CDEC:  circ_pos = (pos == '0) ? bk - 1'b1 : pos - 1'b1;
      M_CADD:  circ_pos = pos_wrap[AW-1:0];
      default: circ_pos = pos;
    endcase
  end

  always_comb begin
    addr    = cur;
    ar_next = cur;
    case (mode)
      M_OFS:                 addr    = cur + offset;
      M_INC:                 ar_next = cur + 1'b1;
      M_DEC:                 ar_next = cur - 1'b1;
      M_ADD:                 ar_next = cur + idx;
      M_CINC, M_CDEC, M_CADD:
        if (!circ_on)
          ar_next = (mode == M_CINC) ? cur + 1'b1 :
                    (mode == M_CDEC) ? cur - 1'b1 : cur + idx;
        else
          ar_next = base | (circ_pos & mask);
      M_REV:                 ar_next = rev_sum;
      default:               ;
    endcase
  end

  for (genvar g = 0; g < NAR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (ld_en && ld_sel == SW'(g))
        bank[g] <= ld_val;
      else if (wr_en && sel == SW'(g))
        bank[g] <= ar_next;
    end
  end

endmodule

module ar_addr_gen_chk #(
  parameter int AW = 16,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] sel,
  input logic [3:0]    mode,
  input logic [AW-1:0] offset,
  input logic [AW-1:0] idx,
  input logic [AW-1:0] bk,
  input logic          wr_en,
  input logic          ld_en,
  input logic [SW-1:0] ld_sel,
  input logic [AW-1:0] ld_val,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] ar_next
);

  logic clash;
  assign clash = ld_en && (ld_sel == sel);

  a_r2_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |-> (ar_next == addr));

  a_r3_offset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd1 && wr_en && !clash) |=>
      ((sel != $past(sel)) || (mode != 4'd0) || (addr == $past(addr) - $past(offset))));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd2) |-> (ar_next == addr + 1'b1));

  a_r6_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode inside {4'd5, 4'd6, 4'd7}) && bk != '0) |->
      ({1'b0, addr ^ ar_next} < {bk, 1'b0}));

  a_r7_linear_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd6 && bk == '0) |-> (ar_next == addr - 1'b1));

  a_r8_rev_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8 && idx == '0) |-> (ar_next == addr));

  a_r9_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clash) |=>
      ((sel != $past(sel)) || (mode != 4'd0) || (addr == $past(ar_next))));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=>
      ((sel != $past(ld_sel)) || (mode != 4'd0) || (addr == $past(ld_val))));

  a_r11_spare_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 4'd9) |-> (ar_next == addr));

endmodule

bind ar_addr_gen ar_addr_gen_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .mode(mode), .offset(offset), .idx(idx),
  .bk(bk), .wr_en(wr_en), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
  .addr(addr), .ar_next(ar_next));

// File: tb/ar_addr_gen_tb.sv
module ar_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0, ld_sel = '0;
  logic [3:0]  mode = '0;
  logic [15:0] offset = '0, idx = '0, bk = '0, ld_val = '0;
  logic        wr_en = 1'b0, ld_en = 1'b0;
  logic [15:0] addr, ar_next;

  int checks = 0, fails = 0;
  bit done = 0;
  int model [8];

  always #10 clk = ~clk;

  ar_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mode(mode), .offset(offset), .idx(idx),
    .bk(bk), .wr_en(wr_en), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .addr(addr), .ar_next(ar_next));

  function automatic int rev16(input int v);
    int r = 0;
    for (int i = 0; i < 16; i++) if (v[i]) r = r | (1 << (15 - i));
    return r;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R2";  1: return "R3";  2, 3: return "R4";  4: return "R5";
      5, 6, 7: return (bk == 0) ? "R7" : "R6";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic predict(input int ar, input int m, output int ea, output int nx);
    int p, pos, np, sum;
    ea = ar; nx = ar;
    case (m)
      1: ea = (ar + offset) % 65536;
      2: nx = (ar + 1) % 65536;
      3: nx = (ar + 65535) % 65536;
      4: nx = (ar + idx) % 65536;
      5, 6, 7: begin
        if (bk == 0) begin
          nx = (m == 5) ? (ar + 1) % 65536 : (m == 6) ? (ar + 65535) % 65536 : (ar + idx) % 65536;
        end else begin
          p = 1;
          while (p < bk) p = p * 2;
          pos = ar % p;
          if (m == 5) begin np = pos + 1; if (np >= bk) np = 0; end
          else if (m == 6) np = (pos == 0) ? bk - 1 : pos - 1;
          else begin sum = pos + idx; np = (sum >= bk) ? sum - bk : sum; end
          nx = ar - pos + (np % p);
        end
      end
      8: nx = rev16((rev16(ar) + rev16(idx)) % 65536);
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%04h expected=%04h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int s, input int m, input int off, input int ix, input int b,
                      input bit we, input bit le, input int ls, input int lv, input string force_tag);
    int ea, nx;
    string t;
    @(negedge clk);
    sel = 3'(s); mode = 4'(m); offset = 16'(off); idx = 16'(ix); bk = 16'(b);
    wr_en = we; ld_en = le; ld_sel = 3'(ls); ld_val = 16'(lv);
    #2;
    predict(model[s], m, ea, nx);
    t = (force_tag != "") ? force_tag : tag_of(m);
    check(t, int'(addr), ea, "addr");
    check(t, int'(ar_next), nx, "ar_next");
    if (we) model[s] = nx;
    if (le) model[ls] = lv;
  endtask

  task automatic load(input int r, input int v);
    step(0, 0, 0, 0, 0, 1'b0, 1'b1, r, v, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(i, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R1");

    load(1, 16'h0103);
    for (int i = 0; i < 4; i++) step(1, 5, 0, 0, 6, 1'b1, 1'b0, 0, 0, "R6");
    step(1, 6, 0, 0, 6, 1'b1, 1'b0, 0, 0, "R6");
    step(1, 6, 0, 0, 6, 1'b1, 1'b0, 0, 0, "R6");
    load(1, 16'h0102);
    step(1, 7, 0, 4, 6, 1'b1, 1'b0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R6");
    load(2, 16'h0038);
    for (int i = 0; i < 9; i++) step(2, 5, 0, 0, 8, 1'b1, 1'b0, 0, 0, "R6");

    load(3, 16'h00F7);
    step(3, 5, 0, 0, 0, 1'b1, 1'b0, 0, 0, "R7");
    step(3, 6, 0, 0, 0, 1'b1, 1'b0, 0, 0, "R7");
    step(3, 7, 0, 16'h0100, 0, 1'b1, 1'b0, 0, 0, "R7");

    load(4, 16'hFFFF);
    step(4, 2, 0, 0, 0, 1'b1, 1'b0, 0, 0, "R4");
    step(4, 3, 0, 0, 0, 1'b1, 1'b0, 0, 0, "R4");
    step(4, 4, 0, 16'h0010, 0, 1'b1, 1'b0, 0, 0, "R5");
    step(4, 1, 16'hFFFE, 0, 0, 1'b1, 1'b0, 0, 0, "R3");
    step(4, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R3");

    load(5, 16'h0000);
    for (int i = 0; i < 8; i++) step(5, 8, 0, 16'h0008, 0, 1'b1, 1'b0, 0, 0, "R8");

    step(6, 2, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R9");
    step(6, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R9");
    step(6, 12, 0, 0, 0, 1'b1, 1'b0, 0, 0, "R11");
    step(6, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R11");

    load(7, 16'h1234);
    step(7, 2, 0, 0, 0, 1'b1, 1'b1, 7, 16'hABCD, "R10");
    step(7, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R10");
    step(7, 2, 0, 0, 0, 1'b1, 1'b1, 0, 16'h5555, "R10");
    step(7, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R10");

    for (int n = 0; n < 3000; n++) begin
      int b;
      b = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 40);
      step($urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 65535),
           $urandom_range(0, 3) == 0 ? $urandom_range(0, 65535) : $urandom_range(0, 12),
           b, 1'($urandom_range(0, 1)), $urandom_range(0, 4) == 0,
           $urandom_range(0, 7), $urandom_range(0, 65535), "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule